// File: doc/BRIEF.md
# External Memory Strobe Cycle Engine

This block turns host transfer commands into byte cycles on an external asynchronous memory bus. The bus has an 8-bit bidirectional data path, a 19-bit address and three active-low strobes: memory-request, read and write. The host gives a start address, a byte count, a direction and a fill flag through one valid/ready command port. Write bytes arrive one at a time through a second valid/ready port, or come from a single fill value. Read bytes are returned with a one-cycle valid pulse. The engine drives every strobe edge from a fixed count of clock cycles. It assumes that ownership of the bus was obtained beforehand.

A count of one gives a single cycle, in which memory-request falls and rises around one strobe. A larger count gives a burst. In a burst, memory-request stays low from the first byte to the last, the address steps up by one after each byte, and only the read or write strobe pulses once per byte. The address goes out as a low byte, a high byte and a 3-bit bank field. A fill command repeats one constant value over the whole range.

Top module: `mem_strobe_engine`

## Requirements
- R1: After reset, mreq_n, rd_n and wr_n are high, data_oe is low, rd_valid and done are low, and cmd_ready is high.
- R2: While a byte is being strobed, {addr_bank, addr_hi, addr_lo} equals the start address plus the byte index, modulo 2^19, with addr_lo holding bits 7:0, addr_hi bits 15:8 and addr_bank bits 18:16.
- R3: Each write byte holds wr_n low for exactly 2 clocks, with data_oe high and data_out and the address unchanged throughout.
- R4: Before wr_n falls, data_out and the address have held steady for at least 2 clocks with data_oe high, mreq_n low and wr_n high.
- R5: Each read byte holds rd_n low for exactly 3 clocks with data_oe low.
- R6: data_in is captured on the last clock that rd_n is low. It appears on rd_data with a one-cycle rd_valid pulse, exactly one pulse per byte read.
- R7: mreq_n falls exactly once per non-empty command and stays low across every byte of a burst. It rises only after a clock in which both strobes were already high.
- R8: A fill command (cmd_write=1, cmd_fill=1) writes cmd_fill_data to each of the cmd_len consecutive addresses and never raises wr_ready.
- R9: A plain write (cmd_write=1, cmd_fill=0) consumes one wr_data byte per wr_valid/wr_ready handshake and writes the bytes in the order given.
- R10: A command with cmd_len=0 raises done in the clock after it is accepted, with no strobe activity and mreq_n kept high.
- R11: done is a one-clock pulse that ends every command. cmd_ready is low from acceptance until done has been seen, and high in the clock after done.
- R12: rd_n and wr_n are never low together, and neither is low while mreq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when cmd_valid is high |
| cmd_addr | input | 19 | Start address |
| cmd_len | input | 16 | Byte count (0 allowed) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_fill | input | 1 | With cmd_write, write cmd_fill_data to every byte |
| cmd_fill_data | input | 8 | Constant fill value |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Engine waiting for a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse, rd_data holds a read byte |
| rd_data | output | 8 | Captured read byte |
| done | output | 1 | One-cycle pulse at command end |
| addr_lo | output | 8 | Bus address bits 7:0 |
| addr_hi | output | 8 | Bus address bits 15:8 |
| addr_bank | output | 3 | Bus address bits 18:16 |
| data_out | output | 8 | Bus data driven during writes |
| data_oe | output | 1 | Output enable for data_out |
| data_in | input | 8 | Bus data sampled during reads |
| mreq_n | output | 1 | Memory-request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The checker's strobe-width and setup counts assume that the host never changes cmd_* while a command is outstanding. They also assume that wr_data is held stable from when wr_valid rises until the handshake completes. The bench keeps to this by issuing a command only when cmd_ready is high and by dropping cmd_valid on the next falling edge. It also changes wr_data only after an observed wr_ready. The bus model returns read data from a fixed function of the driven address and never stalls, so the fixed cycle counts can be compared exactly. Random commands span the full 19-bit address range, including the wrap at the top and crossings of the bank field. Directed cases add empty, single and long commands.

// File: rtl/mse_pkg.sv
// Shared types for the memory strobe cycle engine.
package mse_pkg;

    // Sequencer phases; one byte walks SETUP -> STROBE -> HOLD.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ADDR,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_END
    } mse_state_e;

    // Latched transfer kind.
    typedef struct packed {
        logic write;
        logic fill;
    } mse_mode_t;

endpackage

// File: rtl/mse_phase_timer.sv
// Down-counter that times each bus phase.
// Assumes the load value fits in W bits; zero flags the last cycle of a phase.
module mse_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] count_q;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (count_q != '0)
            count_q <= count_q - W'(1);
    end

    assign zero = (count_q == '0);
endmodule

// File: rtl/mse_addr_gen.sv
// Bus address register: loaded with the start address, stepped by one per byte.
// Wraps modulo 2^ADDR_W; assumes ADDR_W > 16 so a bank field exists.
module mse_addr_gen #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start,
    input  logic              step,
    output logic [7:0]        addr_lo,
    output logic [7:0]        addr_hi,
    output logic [ADDR_W-17:0] addr_bank
);
    logic [ADDR_W-1:0] addr_q;

    // Hold the current byte address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load)
            addr_q <= start;
        else if (step)
            addr_q <= addr_q + ADDR_W'(1);
    end

    assign addr_lo   = addr_q[7:0];
    assign addr_hi   = addr_q[15:8];
    assign addr_bank = addr_q[ADDR_W-1:16];
endmodule

// File: rtl/mse_data_path.sv
// Data registers: the outgoing write byte and the captured read byte.
// Assumes sample is asserted only on the last low clock of a read strobe.
module mse_data_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_load,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              wr_take,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sample,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0] wbyte_q;
    logic [DATA_W-1:0] rbyte_q;
    logic              rvalid_q;

    // Keep the byte that the bus drives during writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wbyte_q <= '0;
        else if (fill_load)
            wbyte_q <= fill_data;
        else if (wr_take)
            wbyte_q <= wr_data;
    end

    // Capture read data and pulse its valid flag for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbyte_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= sample;
            if (sample)
                rbyte_q <= data_in;
        end
    end

    assign data_out = wbyte_q;
    assign rd_data  = rbyte_q;
    assign rd_valid = rvalid_q;
endmodule

// File: rtl/mse_ctrl.sv
// Cycle sequencer: walks each byte through address, setup, strobe and hold
// phases and keeps memory-request low for the whole command.
// Assumes the bus is already granted and the target inserts no wait states.
module mse_ctrl
    import mse_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int TMR_W    = 4,
    parameter int WR_SETUP = 2,
    parameter int WR_LOW   = 2,
    parameter int RD_SETUP = 1,
    parameter int RD_LOW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             cmd_write,
    input  logic             cmd_fill,
    input  logic             wr_valid,
    input  logic             tmr_zero,
    output logic             cmd_ready,
    output logic             wr_ready,
    output logic             done,
    output logic             accept,
    output logic             fill_load,
    output logic             wr_take,
    output logic             addr_step,
    output logic             rd_sample,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             mreq_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic             data_oe
);
    mse_state_e       state_q, state_d;
    mse_mode_t        mode_q;
    logic [LEN_W-1:0] remain_q;
    logic             first_q;
    logic [TMR_W-1:0] setup_val;
    logic [TMR_W-1:0] low_val;
    logic             mreq_on;

    assign setup_val = mode_q.write ? TMR_W'(WR_SETUP - 1) : TMR_W'(RD_SETUP - 1);
    assign low_val   = mode_q.write ? TMR_W'(WR_LOW - 1)   : TMR_W'(RD_LOW - 1);

    // Choose the next phase and the timer load for it.
    always_comb begin
        state_d   = state_q;
        accept    = 1'b0;
        addr_step = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    accept = 1'b1;
                    if (cmd_len == '0)
                        state_d = ST_END;
                    else if (cmd_write && !cmd_fill)
                        state_d = ST_WAIT;
                    else
                        state_d = ST_ADDR;
                end
            end
            ST_WAIT: begin
                if (wr_valid) begin
                    if (first_q) begin
                        state_d = ST_ADDR;
                    end else begin
                        state_d  = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = setup_val;
                    end
                end
            end
            ST_ADDR: begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = setup_val;
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = low_val;
                end
            end
            ST_STROBE: begin
                if (tmr_zero)
                    state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (remain_q == LEN_W'(1)) begin
                    state_d = ST_END;
                end else begin
                    addr_step = 1'b1;
                    if (mode_q.write && !mode_q.fill) begin
                        state_d = ST_WAIT;
                    end else begin
                        state_d  = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = setup_val;
                    end
                end
            end
            ST_END:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Advance the phase and keep command bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= '0;
            remain_q <= '0;
            first_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                mode_q.write <= cmd_write;
                mode_q.fill  <= cmd_write & cmd_fill;
                remain_q     <= cmd_len;
                first_q      <= 1'b1;
            end
            if (state_q == ST_ADDR)
                first_q <= 1'b0;
            if (state_q == ST_HOLD)
                remain_q <= remain_q - LEN_W'(1);
        end
    end

    assign mreq_on   = (state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                       (state_q == ST_HOLD)  || ((state_q == ST_WAIT) && !first_q);
    assign mreq_n    = !mreq_on;
    assign wr_n      = !((state_q == ST_STROBE) && mode_q.write);
    assign rd_n      = !((state_q == ST_STROBE) && !mode_q.write);
    assign data_oe   = mode_q.write && mreq_on;
    assign cmd_ready = (state_q == ST_IDLE);
    assign wr_ready  = (state_q == ST_WAIT);
    assign done      = (state_q == ST_END);
    assign fill_load = accept && cmd_write && cmd_fill;
    assign wr_take   = (state_q == ST_WAIT) && wr_valid;
    assign rd_sample = (state_q == ST_STROBE) && tmr_zero && !mode_q.write;
endmodule

// File: rtl/mem_strobe_engine.sv
// Top level: single and burst byte transfers on an asynchronous strobed
// memory bus. Assumes the bus is already owned and needs no wait states.
module mem_strobe_engine #(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 16,
    parameter int WR_SETUP = 2,
    parameter int WR_LOW   = 2,
    parameter int RD_SETUP = 1,
    parameter int RD_LOW   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic               cmd_write,
    input  logic               cmd_fill,
    input  logic [DATA_W-1:0]  cmd_fill_data,
    input  logic               wr_valid,
    output logic               wr_ready,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               done,
    output logic [7:0]         addr_lo,
    output logic [7:0]         addr_hi,
    output logic [ADDR_W-17:0] addr_bank,
    output logic [DATA_W-1:0]  data_out,
    output logic               data_oe,
    input  logic [DATA_W-1:0]  data_in,
    output logic               mreq_n,
    output logic               rd_n,
    output logic               wr_n
);
    localparam int SETUP_MAX = (WR_SETUP > RD_SETUP) ? WR_SETUP : RD_SETUP;
    localparam int LOW_MAX   = (WR_LOW > RD_LOW) ? WR_LOW : RD_LOW;
    localparam int CYC_MAX   = (SETUP_MAX > LOW_MAX) ? SETUP_MAX : LOW_MAX;
    localparam int TMR_W     = (CYC_MAX < 2) ? 1 : $clog2(CYC_MAX);

    logic             accept;
    logic             fill_load;
    logic             wr_take;
    logic             addr_step;
    logic             rd_sample;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;

    mse_ctrl #(
        .LEN_W(LEN_W), .TMR_W(TMR_W),
        .WR_SETUP(WR_SETUP), .WR_LOW(WR_LOW),
        .RD_SETUP(RD_SETUP), .RD_LOW(RD_LOW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_len(cmd_len),
        .cmd_write(cmd_write), .cmd_fill(cmd_fill),
        .wr_valid(wr_valid), .tmr_zero(tmr_zero),
        .cmd_ready(cmd_ready), .wr_ready(wr_ready), .done(done),
        .accept(accept), .fill_load(fill_load), .wr_take(wr_take),
        .addr_step(addr_step), .rd_sample(rd_sample),
        .tmr_load(tmr_load), .tmr_val(tmr_val),
        .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .data_oe(data_oe)
    );

    mse_phase_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    mse_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load(accept), .start(cmd_addr), .step(addr_step),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .addr_bank(addr_bank)
    );

    mse_data_path #(.DATA_W(DATA_W)) u_data (
        .clk(clk), .rst_n(rst_n),
        .fill_load(fill_load), .fill_data(cmd_fill_data),
        .wr_take(wr_take), .wr_data(wr_data),
        .sample(rd_sample), .data_in(data_in),
        .data_out(data_out), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/mse_checker.sv
// Protocol checker for the memory strobe cycle engine, bound to the top.
module mse_checker #(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int WR_SETUP = 2,
    parameter int WR_LOW   = 2,
    parameter int RD_LOW   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mreq_n,
    input logic               rd_n,
    input logic               wr_n,
    input logic               data_oe,
    input logic [DATA_W-1:0]  data_out,
    input logic [7:0]         addr_lo,
    input logic [7:0]         addr_hi,
    input logic [ADDR_W-17:0] addr_bank,
    input logic               rd_valid,
    input logic               done,
    input logic               cmd_ready
);
    logic [7:0]        wr_run;
    logic [7:0]        rd_run;
    logic [7:0]        setup_run;
    logic [DATA_W-1:0] data_prev;
    logic [ADDR_W-1:0] addr_prev;
    logic [ADDR_W-1:0] addr_now;

    assign addr_now = {addr_bank, addr_hi, addr_lo};

    // Count strobe-low lengths and steady write-setup cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_run    <= '0;
            rd_run    <= '0;
            setup_run <= '0;
            data_prev <= '0;
            addr_prev <= '0;
        end else begin
            wr_run    <= !wr_n ? ((wr_run == 8'hFF) ? wr_run : wr_run + 8'd1) : 8'd0;
            rd_run    <= !rd_n ? ((rd_run == 8'hFF) ? rd_run : rd_run + 8'd1) : 8'd0;
            if (wr_n && data_oe && !mreq_n)
                setup_run <= (data_out == data_prev && addr_now == addr_prev && setup_run != 8'hFF)
                             ? setup_run + 8'd1 : 8'd1;
            else
                setup_run <= 8'd0;
            data_prev <= data_out;
            addr_prev <= addr_now;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n)); // R12
    AST_STROBE_UNDER_MREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !mreq_n); // R12
    AST_WR_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> data_oe); // R3
    AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !$past(wr_n)) |-> ($stable(data_out) && $stable(addr_now))); // R3
    AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (wr_run == 8'(WR_LOW))); // R3
    AST_WR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> (setup_run >= 8'(WR_SETUP) && $stable(data_out) && $stable(addr_now))); // R4
    AST_RD_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !data_oe); // R5
    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (rd_run == 8'(RD_LOW))); // R5
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6
    AST_MREQ_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mreq_n) |-> ($past(rd_n) && $past(wr_n))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mreq_n |-> !cmd_ready); // R11
endmodule

bind mem_strobe_engine mse_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WR_SETUP(WR_SETUP), .WR_LOW(WR_LOW), .RD_LOW(RD_LOW)
) i_mse_checker (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .data_oe(data_oe), .data_out(data_out),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .addr_bank(addr_bank),
    .rd_valid(rd_valid), .done(done), .cmd_ready(cmd_ready)
);

// File: tb/test_mem_strobe_engine.sv
module test_mem_strobe_engine;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [18:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic        cmd_write = 1'b0;
    logic        cmd_fill = 1'b0;
    logic [7:0]  cmd_fill_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        done;
    logic [7:0]  addr_lo, addr_hi;
    logic [2:0]  addr_bank;
    logic [7:0]  data_out;
    logic        data_oe;
    logic [7:0]  data_in;
    logic        mreq_n, rd_n, wr_n;
    logic [18:0] busaddr;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    // monitor storage
    int          ev_n, rv_n, mfalls, viol, wrun, rrun, pre;
    bit          wrrdy_seen, fill_on;
    logic [18:0] ev_addr [MAXB];
    logic [7:0]  ev_data [MAXB];
    int          ev_w    [MAXB];
    int          ev_pre  [MAXB];
    bit          ev_wr   [MAXB];
    logic [7:0]  rv_data [MAXB];
    logic [7:0]  wdat    [MAXB];
    logic        p_wr = 1'b1, p_rd = 1'b1, p_mreq = 1'b1;
    logic [7:0]  p_data = '0;
    logic [18:0] p_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign busaddr = {addr_bank, addr_hi, addr_lo};

    function automatic logic [7:0] model_byte(input logic [18:0] a);
        return a[7:0] ^ {a[15:8]} ^ {a[18:16], 5'b10110} ^ 8'h3C;
    endfunction

    assign data_in = model_byte(busaddr);

    mem_strobe_engine i_mem_strobe_engine (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_write(cmd_write), .cmd_fill(cmd_fill),
        .cmd_fill_data(cmd_fill_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .addr_bank(addr_bank),
        .data_out(data_out), .data_oe(data_oe), .data_in(data_in),
        .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Global watchdog: a hang counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
                summary();
            end
        end
    end

    // Bus monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!rd_n && !wr_n) viol++;
            if ((!rd_n || !wr_n) && mreq_n) viol++;
            if (!wr_n && p_wr && ev_n < MAXB) begin
                ev_addr[ev_n] = busaddr; ev_data[ev_n] = data_out;
                ev_pre[ev_n] = pre; ev_wr[ev_n] = 1'b1; ev_n++;
            end
            if (!rd_n && p_rd && ev_n < MAXB) begin
                ev_addr[ev_n] = busaddr; ev_data[ev_n] = 8'h00;
                ev_pre[ev_n] = 0; ev_wr[ev_n] = 1'b0; ev_n++;
            end
            if (wr_n && !p_wr && ev_n > 0) ev_w[ev_n-1] = wrun;
            if (rd_n && !p_rd && ev_n > 0) ev_w[ev_n-1] = rrun;
            wrun = !wr_n ? wrun + 1 : 0;
            rrun = !rd_n ? rrun + 1 : 0;
            if (wr_n && data_oe && !mreq_n)
                pre = (data_out == p_data && busaddr == p_addr) ? pre + 1 : 1;
            else
                pre = 0;
            if (rd_valid && rv_n < MAXB) begin rv_data[rv_n] = rd_data; rv_n++; end
            if (!mreq_n && p_mreq) mfalls++;
            if (wr_ready && fill_on) wrrdy_seen = 1'b1;
            p_wr = wr_n; p_rd = rd_n; p_mreq = mreq_n;
            p_data = data_out; p_addr = busaddr;
        end
    end

    // kind: 0 read, 1 write, 2 fill
    task automatic run_op(input int kind, input logic [18:0] a, input int len);
        logic [7:0] fv;
        fv = 8'($urandom);
        for (int i = 0; i < MAXB; i++) wdat[i] = (kind == 2) ? fv : 8'($urandom);
        @(negedge clk);
        ev_n = 0; rv_n = 0; mfalls = 0; wrrdy_seen = 1'b0; fill_on = (kind == 2);
        cmd_addr = a; cmd_len = 16'(len); cmd_write = (kind != 0);
        cmd_fill = (kind == 2); cmd_fill_data = fv; cmd_valid = 1'b1;
        chk(cmd_ready == 1'b1, "R11", "ready before issue", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        fork
            begin
                if (kind == 1) begin
                    for (int i = 0; i < len; i++) begin
                        wr_valid = 1'b1; wr_data = wdat[i];
                        while (!wr_ready) @(negedge clk);
                        @(negedge clk);
                    end
                    wr_valid = 1'b0;
                end
            end
            begin
                if (len > 0) chk(cmd_ready == 1'b0, "R11", "busy after accept", cmd_ready, 0);
                while (!done) @(negedge clk);
            end
        join
        @(negedge clk);
        chk(done == 1'b0 && cmd_ready == 1'b1, "R11", "done pulse then ready",
            {done, cmd_ready}, 2'b01);
        chk(ev_n == len, "R2", "strobe count", ev_n, len);
        chk(mfalls == 1, "R7", "mreq falls per command", mfalls, 1);
        chk(rv_n == ((kind == 0) ? len : 0), "R6", "rd_valid pulse count", rv_n,
            (kind == 0) ? len : 0);
        if (kind == 2) chk(!wrrdy_seen, "R8", "wr_ready during fill", wrrdy_seen, 0);
        for (int i = 0; i < ev_n && i < len; i++) begin
            logic [18:0] ea;
            ea = a + 19'(i);
            chk(ev_addr[i] == ea, "R2", "byte address", ev_addr[i], ea);
            chk(ev_wr[i] == (kind != 0), "R12", "strobe kind", ev_wr[i], kind != 0);
            if (kind == 0) begin
                chk(ev_w[i] == 3, "R5", "rd_n low width", ev_w[i], 3);
                chk(rv_data[i] == model_byte(ea), "R6", "read byte", rv_data[i], model_byte(ea));
            end else begin
                chk(ev_w[i] == 2, "R3", "wr_n low width", ev_w[i], 2);
                chk(ev_pre[i] >= 2, "R4", "write setup cycles", ev_pre[i], 2);
                chk(ev_data[i] == wdat[i], (kind == 2) ? "R8" : "R9", "write byte",
                    ev_data[i], wdat[i]);
            end
        end
        chk(viol == 0, "R12", "strobe overlap or outside mreq", viol, 0);
    endtask

    task automatic run_zero(input bit wr);
        @(negedge clk);
        ev_n = 0; mfalls = 0;
        cmd_addr = 19'h12345; cmd_len = 16'd0; cmd_write = wr; cmd_fill = 1'b0;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(done == 1'b1, "R10", "done one clock after empty command", done, 1);
        chk(mreq_n == 1'b1 && wr_ready == 1'b0, "R10", "no bus activity",
            {mreq_n, wr_ready}, 2'b10);
        @(negedge clk);
        chk(done == 1'b0 && cmd_ready == 1'b1, "R11", "empty command ends", {done, cmd_ready}, 2'b01);
        chk(ev_n == 0 && mfalls == 0, "R10", "no strobes", ev_n + mfalls, 0);
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'h1F2E3D));
        viol = 0; wrun = 0; rrun = 0; pre = 0;
        repeat (3) @(negedge clk);
        chk(mreq_n && rd_n && wr_n && !data_oe && !rd_valid && !done && cmd_ready,
            "R1", "reset outputs",
            {mreq_n, rd_n, wr_n, data_oe, rd_valid, done, cmd_ready}, 7'b1110001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mreq_n && rd_n && wr_n && !data_oe && cmd_ready, "R1", "idle after reset",
            {mreq_n, rd_n, wr_n, data_oe, cmd_ready}, 5'b11101);
        // directed corners
        run_op(1, 19'h00010, 1);   // single write, R9
        run_op(0, 19'h00010, 1);   // single read, R6
        run_zero(1'b0);            // R10
        run_zero(1'b1);            // R10
        run_op(2, 19'h0FFF8, 16);  // fill across bank field, R8 R2
        run_op(0, 19'h7FFFD, 6);   // read burst wrapping at top, R2
        run_op(1, 19'h3FFFE, 20);  // long write burst, R9
        run_op(0, 19'h1FF00, 40);  // long read burst
        // constrained random
        for (int n = 0; n < 40; n++) begin
            run_op(int'($urandom_range(0, 2)), 19'($urandom), int'($urandom_range(1, 12)));
        end
        summary();
    end
endmodule